// File: doc/BRIEF.md
# Dual Gated Timer-Counter Pair

This block holds two independent 16-bit timer/counters. Each is kept as a low byte and a high byte that software reaches separately over a small register bus. A shared mode register chooses, for each timer, what it counts:

- Prescaled clock ticks: one increment every 12 clocks, or every 4 when fast prescale is chosen.
- Falling edges seen on the timer's external count pin.

Counting can be held off by a run bit and, optionally, by a gate pin.

Each timer works either as a full 16-bit counter or as an 8-bit counter that reloads its low byte from its high byte on overflow. An overflow sets a sticky flag that software clears. Timer 1 overflows also leave the block as a one-cycle tick, meant to serve as the bit-rate clock of a serial port.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every readable register reads 0, ovf_flag is 0 and baud_tick is 0.
- R2: Register map on bus_addr:
  - 0 is the mode register. Bits [3:0] configure timer 0 and bits [7:4] configure timer 1. In each nibble, bit 0 selects event counting, bit 1 enables the gate, bit 2 selects 8-bit reload and bit 3 selects fast prescale.
  - 1 is the control register. Bit 0 is run0 and bit 1 is run1. Bits 2 and 3 are the overflow flags of timer 0 and timer 1.
  - 2 and 3 are the low and high bytes of timer 0.
  - 4 and 5 are the low and high bytes of timer 1.
  - 6 and 7 read 0.
- R3: In tick mode with fast prescale clear, a running timer increments exactly once every 12 clocks.
- R4: In tick mode with fast prescale set, a running timer increments exactly once every 4 clocks.
- R5: In event mode the count pin is sampled on every clock, and each 1-to-0 change between successive samples adds exactly one. A steady level adds nothing.
- R6: With the gate enable bit set, a low gate pin stops all counting. With the gate enable bit clear, the gate pin has no effect.
- R7: With its run bit clear, a timer never changes except by a bus write.
- R8: In 16-bit mode, an increment from 0xFFFF gives 0x0000 and sets that timer's overflow flag.
- R9: In 8-bit reload mode only the low byte counts. An increment from 0xFF loads the low byte from the high byte, leaves the high byte unchanged and sets the overflow flag.
- R10: Overflow flags are sticky. Writing 0 to a flag bit in the control register clears it. Writing 1 leaves it unchanged.
- R11: A bus write to either count byte of a timer takes priority over an increment due in the same cycle, and that increment is discarded.
- R12: baud_tick is high for exactly one cycle, the cycle after each timer 1 overflow. Timer 0 overflows never produce it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cnt_pin | input | 2 | External count inputs, bit i for timer i |
| gate_pin | input | 2 | Gate inputs, bit i for timer i |
| ovf_flag | output | 2 | Sticky overflow flags |
| baud_tick | output | 1 | One-cycle pulse after each timer 1 overflow |

## Verification
Several properties are checked by assertions on every cycle:
- The prescaler's fast and slow ticks stay in phase.
- Any event-mode increment is preceded by a high sample followed by a low sample.
- A bus write wins over a coincident increment.
- A 16-bit wrap lands on zero, and an 8-bit reload copies the high byte.
- An idle timer holds its value.
- Flags stay set until a clearing write.
- A baud tick always comes with timer 1's flag raised.

Some behaviour only the scenarios can show: the actual 12- and 4-clock periods, exact edge counts under a closed or ignored gate, the run-bit hold, the rule that writing 1 to a flag is harmless, and the absence of a baud tick on timer 0 overflow.

// File: rtl/tmr_pkg.sv
// Package: shared constants and the per-timer configuration nibble.
// Assumes two timers and an 8-bit register bus with a 3-bit address.
package tmr_pkg;
    localparam int NUM_TMR = 2;
    localparam int CFG_W   = 4;
    localparam int ADDR_W  = 3;

    // Per-timer configuration nibble, packed MSB first:
    // bit3 fast prescale, bit2 8-bit reload, bit1 gate enable, bit0 event mode
    typedef struct packed {
        logic fast;
        logic reload8;
        logic gate_en;
        logic evt;
    } tmr_cfg_t;

    localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd1;
    localparam int                ADR_CNT_BASE = 2;
endpackage

// File: rtl/tmr_prescale.sv
// Module: tmr_prescale
// Free-running divider giving a slow tick every SLOW_DIV clocks and a fast
// tick every FAST_DIV clocks. Both counters start at zero on reset.
// Assumes SLOW_DIV is a multiple of FAST_DIV, so every slow tick is also a fast tick.
module tmr_prescale #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_slow,
    output logic tick_fast
);
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
    localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);

    logic [SW-1:0] slow_ph;
    logic [FW-1:0] fast_ph;

    // Advance the slow phase counter, wrapping at SLOW_DIV
    always_ff @(posedge clk) begin
        if (!rst_n)                  slow_ph <= '0;
        else if (slow_ph == SLOW_LAST) slow_ph <= '0;
        else                         slow_ph <= slow_ph + 1'b1;
    end

    // Advance the fast phase counter, wrapping at FAST_DIV
    always_ff @(posedge clk) begin
        if (!rst_n)                  fast_ph <= '0;
        else if (fast_ph == FAST_LAST) fast_ph <= '0;
        else                         fast_ph <= fast_ph + 1'b1;
    end

    assign tick_slow = (slow_ph == SLOW_LAST);
    assign tick_fast = (fast_ph == FAST_LAST);

    // R3/R4: the two dividers stay phase-aligned
    a_r3_slow_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
        tick_slow |-> tick_fast);
    a_r3_slow_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick_slow |=> !tick_slow);
endmodule

// File: rtl/tmr_trigger.sv
// Module: tmr_trigger
// Turns the source selection, pin edge detection, gate and run bit into one
// increment request per clock for a single timer.
// Assumes pin and gate are already synchronous to clk.
module tmr_trigger
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  logic     gate,
    input  logic     run,
    input  tmr_cfg_t cfg,
    input  logic     tick_slow,
    input  logic     tick_fast,
    output logic     inc
);
    logic smp_cur;
    logic smp_prev;
    logic fall;
    logic src;
    logic gate_open;

    // Sample the count pin every clock and keep the previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_cur  <= 1'b0;
            smp_prev <= 1'b0;
        end else begin
            smp_cur  <= pin;
            smp_prev <= smp_cur;
        end
    end

    // Choose the count source and apply the gate and run qualifiers
    always_comb begin
        fall      = smp_prev & ~smp_cur;
        src       = cfg.evt ? fall : (cfg.fast ? tick_fast : tick_slow);
        gate_open = ~cfg.gate_en | gate;
        inc       = run & gate_open & src;
    end

    // R5: an event increment follows a high sample then a low sample
    a_r5_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cfg.evt) |-> ($past(pin, 2) && !$past(pin)));
endmodule

// File: rtl/tmr_count.sv
// Module: tmr_count
// One timer's count register as a low and a high byte. It counts as 16 bits
// or as an 8-bit low byte that reloads from the high byte. A bus write to
// either byte cancels an increment due in the same cycle. 'wrap' flags the
// increment that overflows.
module tmr_count #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              reload8,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              wrap
);
    logic step;
    logic lo_full;
    logic hi_full;

    // Decode the increment and overflow conditions
    always_comb begin
        step    = inc & ~(wr_lo | wr_hi);
        lo_full = &lo;
        hi_full = &hi;
        wrap    = step & lo_full & (reload8 | hi_full);
    end

    // Update the low byte: write, reload or increment
    always_ff @(posedge clk) begin
        if (!rst_n)                lo <= '0;
        else if (wr_lo)            lo <= wdata;
        else if (step) begin
            if (reload8 && lo_full) lo <= hi;
            else                   lo <= lo + 1'b1;
        end
    end

    // Update the high byte: write or carry in 16-bit mode
    always_ff @(posedge clk) begin
        if (!rst_n)                                lo_hi_reset();
        else if (wr_hi)                            hi <= wdata;
        else if (step && !reload8 && lo_full)      hi <= hi + 1'b1;
    end

    task automatic lo_hi_reset();
        hi <= '0;
    endtask

    // R11: a written byte holds the written value next cycle
    a_r11_write_lo_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo == $past(wdata)));
    a_r11_write_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (hi == $past(wdata)));
    // R8: a 16-bit wrap lands on zero
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !reload8) |=> (lo == '0 && hi == '0));
    // R9: an 8-bit reload copies the high byte and keeps it
    a_r9_reload_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && reload8) |=> (lo == $past(hi) && hi == $past(hi)));
    // R7: no increment and no write leaves the count unchanged
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/tmr_pair.sv
// Module: tmr_pair (top)
// Two gated timer/counters behind a small register bus. Holds the mode, run
// and sticky flag registers, decodes bus writes, muxes reads, and registers
// timer 1's overflow as the baud tick.
// Assumes one bus write per cycle. Reads are combinational on bus_addr.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    input  logic                 bus_we,
    output logic [BYTE_W-1:0]    bus_rdata,
    input  logic [NUM_TMR-1:0]   cnt_pin,
    input  logic [NUM_TMR-1:0]   gate_pin,
    output logic [NUM_TMR-1:0]   ovf_flag,
    output logic                 baud_tick
);
    localparam int MODE_W = CFG_W * NUM_TMR;
    localparam int BAUD_T = NUM_TMR - 1;

    logic [MODE_W-1:0]  mode_q;
    logic [NUM_TMR-1:0] run_q;
    logic [NUM_TMR-1:0] flag_q;
    logic               baud_q;
    logic               mode_wr;
    logic               ctrl_wr;
    logic               tick_slow;
    logic               tick_fast;
    logic [NUM_TMR-1:0] inc;
    logic [NUM_TMR-1:0] wrap;
    logic [NUM_TMR-1:0] wr_lo;
    logic [NUM_TMR-1:0] wr_hi;
    logic [BYTE_W-1:0]  lo_v [NUM_TMR];
    logic [BYTE_W-1:0]  hi_v [NUM_TMR];

    // Decode writes to the mode and control registers
    always_comb begin
        mode_wr = bus_we && (bus_addr == ADR_MODE);
        ctrl_wr = bus_we && (bus_addr == ADR_CTRL);
    end

    // Hold the mode register
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= bus_wdata[MODE_W-1:0];
    end

    // Hold the run bits
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (ctrl_wr) run_q <= bus_wdata[NUM_TMR-1:0];
    end

    // Keep sticky flags: an overflow sets, a written 0 clears, and set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (wrap[i])                              flag_q[i] <= 1'b1;
                else if (ctrl_wr && !bus_wdata[NUM_TMR+i]) flag_q[i] <= 1'b0;
            end
        end
    end

    // Register the last timer's overflow as the baud tick
    always_ff @(posedge clk) begin
        if (!rst_n) baud_q <= 1'b0;
        else        baud_q <= wrap[BAUD_T];
    end

    tmr_prescale #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tmr_cfg_t cfg;
        assign cfg      = tmr_cfg_t'(mode_q[CFG_W*g +: CFG_W]);
        assign wr_lo[g] = bus_we && (bus_addr == ADDR_W'(ADR_CNT_BASE + 2*g));
        assign wr_hi[g] = bus_we && (bus_addr == ADDR_W'(ADR_CNT_BASE + 2*g + 1));

        tmr_trigger u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (cnt_pin[g]),
            .gate      (gate_pin[g]),
            .run       (run_q[g]),
            .cfg       (cfg),
            .tick_slow (tick_slow),
            .tick_fast (tick_fast),
            .inc       (inc[g])
        );

        tmr_count #(.BYTE_W(BYTE_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc[g]),
            .reload8 (cfg.reload8),
            .wr_lo   (wr_lo[g]),
            .wr_hi   (wr_hi[g]),
            .wdata   (bus_wdata),
            .lo      (lo_v[g]),
            .hi      (hi_v[g]),
            .wrap    (wrap[g])
        );

        // R10: a set flag survives anything but a clearing control write
        a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !(ctrl_wr && !bus_wdata[NUM_TMR+g])) |=> flag_q[g]);
        // R7: a stopped timer requests no increment
        a_r7_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[g]) |-> !inc[g]);
    end

    // Drive read data for the addressed register
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_MODE)      bus_rdata = BYTE_W'(mode_q);
        else if (bus_addr == ADR_CTRL) bus_rdata = BYTE_W'({flag_q, run_q});
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(ADR_CNT_BASE + 2*i))     bus_rdata = lo_v[i];
            if (bus_addr == ADDR_W'(ADR_CNT_BASE + 2*i + 1)) bus_rdata = hi_v[i];
        end
    end

    assign ovf_flag  = flag_q;
    assign baud_tick = baud_q;

    // R12: a baud tick always comes with the last timer's flag raised
    a_r12_baud_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> ovf_flag[BAUD_T]);
endmodule

// File: tb/sim_tmr_pair.sv
// Directed bench for tmr_pair: one task per scenario, each checking itself.
module sim_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b11;
    logic [1:0] ovf_flag;
    logic       baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    int baud_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_pair u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_flag(ovf_flag), .baud_tick(baud_tick)
    );

    always @(negedge clk) if (rst_n && baud_tick) baud_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_pin[idx] = 1'b0;
            repeat (3) @(negedge clk);
            cnt_pin[idx] = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    // Clocks between two successive changes of timer 0's low byte
    task automatic period(output int n);
        int prev;
        int waited;
        @(negedge clk); bus_addr = 3'd2; #1 prev = bus_rdata;
        waited = 0;
        while (bus_rdata == prev && waited < 100) begin
            @(negedge clk); #1 waited++;
        end
        prev = bus_rdata;
        n = 0;
        while (bus_rdata == prev && n < 100) begin
            @(negedge clk); #1 n++;
        end
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset flags", ovf_flag, 0);
        check("R1 reset baud", baud_tick, 0);
    endtask

    task automatic t_slow();
        int n;
        int v1;
        int v2;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        period(n);
        check("R3 slow period", n, 12);
        period(n);
        check("R3 slow period again", n, 12);
        wr(3'd1, 8'h00);
        rd(3'd2, v1);
        repeat (40) @(negedge clk);
        rd(3'd2, v2);
        check("R7 stopped timer holds", v2, v1);
    endtask

    task automatic t_fast();
        int n;
        int v;
        wr(3'd0, 8'h08);
        rd(3'd0, v);
        check("R2 mode readback", v, 8'h08);
        wr(3'd1, 8'h01);
        period(n);
        check("R4 fast period", n, 4);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_event();
        int v;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h01);
        pulse(0, 5);
        rd(3'd2, v);
        check("R5 five falling edges", v, 5);
        repeat (30) @(negedge clk);
        rd(3'd2, v);
        check("R5 steady level adds nothing", v, 5);
    endtask

    task automatic t_gate();
        int v;
        wr(3'd0, 8'h03);
        gate_pin[0] = 1'b0;
        pulse(0, 3);
        rd(3'd2, v);
        check("R6 closed gate blocks", v, 5);
        gate_pin[0] = 1'b1;
        pulse(0, 2);
        rd(3'd2, v);
        check("R6 open gate counts", v, 7);
        wr(3'd0, 8'h01);
        gate_pin[0] = 1'b0;
        pulse(0, 1);
        rd(3'd2, v);
        check("R6 gate ignored when disabled", v, 8);
        gate_pin[0] = 1'b1;
    endtask

    task automatic t_wrap16();
        int v;
        int b0;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd1, 8'h01);
        b0 = baud_cnt;
        pulse(0, 1);
        rd(3'd2, v); check("R8 wrap low byte", v, 0);
        rd(3'd3, v); check("R8 wrap high byte", v, 0);
        check("R8 flag0 set", ovf_flag[0], 1);
        check("R12 no baud from timer0", baud_cnt, b0);
        rd(3'd1, v); check("R2 ctrl readback", v, 8'h05);
    endtask

    task automatic t_flags();
        wr(3'd1, 8'h05);
        check("R10 write 1 keeps flag", ovf_flag[0], 1);
        wr(3'd1, 8'h01);
        check("R10 write 0 clears flag", ovf_flag[0], 0);
    endtask

    task automatic t_reload8();
        int v;
        int b0;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h50);
        wr(3'd5, 8'hF0);
        wr(3'd4, 8'hFE);
        wr(3'd1, 8'h02);
        b0 = baud_cnt;
        pulse(1, 1);
        rd(3'd4, v); check("R9 low byte to FF", v, 8'hFF);
        check("R9 no flag before overflow", ovf_flag[1], 0);
        pulse(1, 1);
        rd(3'd4, v); check("R9 reload from high", v, 8'hF0);
        rd(3'd5, v); check("R9 high byte kept", v, 8'hF0);
        check("R9 flag1 set", ovf_flag[1], 1);
        check("R12 one baud tick", baud_cnt - b0, 1);
        pulse(1, 16);
        rd(3'd4, v); check("R9 second reload", v, 8'hF0);
        check("R12 two baud ticks", baud_cnt - b0, 2);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_prio();
        int v;
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h20);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h01);
        repeat (4) @(negedge clk);
        @(negedge clk); cnt_pin[0] = 1'b0;
        @(negedge clk); bus_addr = 3'd2; bus_wdata = 8'h55; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        repeat (3) @(negedge clk);
        cnt_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd2, v); check("R11 write beats increment", v, 8'h55);
        rd(3'd3, v); check("R11 high byte untouched", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_slow();
        t_fast();
        t_event();
        t_gate();
        t_wrap16();
        t_flags();
        t_reload8();
        t_prio();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule